// File: doc/BRIEF.md
# Two-Wire SCL Waveform Generator

This block produces the SCL level request for a two-wire bus master, derived from the system clock. The low and high halves of each SCL period are timed separately. Each half lasts a number of system clocks equal to its own 8-bit divisor, shifted left by a shared prescale exponent, plus a fixed offset set at build time. With equal divisors the SCL period is `2 * (div * 2^exp + OFFSET)` system clocks. Software works out the divisor and exponent for its target bus rate and writes them into the configuration word.

The block also gives the bit engine two single-cycle strobes. One marks the middle of each low phase, where SDA may change. The other marks the middle of each high phase, where SDA is sampled. While the run enable is low, SCL is held high and the phase counter stays cleared. When run rises, the first phase is a low phase. The configuration word is read only at the moment a new phase is loaded, so a write made part-way through a phase first takes effect at the next phase edge.

Top module: `scl_wavegen`

## Requirements
- R1: While `run_i` is low (and after reset), `scl_o` is 1 and both strobes are 0 from the next clock edge onward.
- R2: A low phase lasts `(cfg_i[7:0] << e) + OFFSET` system clocks, where `e` is the effective exponent.
- R3: A high phase lasts `(cfg_i[15:8] << e) + OFFSET` system clocks.
- R4: The exponent field occupies `cfg_i` bits from 16 upward, `$clog2(MAX_EXP+1)` bits wide. A value above `MAX_EXP` is treated as `MAX_EXP`.
- R5: When `run_i` is first sampled high from idle, `scl_o` goes to 0 at that same edge, and the first phase is a low phase.
- R6: `cfg_i` is sampled only at the edge that loads a phase. A change made inside a phase leaves that phase's length unchanged and applies from the next phase.
- R7: `drive_stb_o` pulses exactly once per low phase of length L, at cycle index `L-1-floor(L/2)` counted from 0 at the first low cycle.
- R8: `sample_stb_o` pulses exactly once per high phase of length L, at cycle index `L-1-floor(L/2)`.
- R9: `drive_stb_o` is never high while `scl_o` is 1, and `sample_stb_o` is never high while `scl_o` is 0.
- R10: The slowest setting (exponent at its maximum, divisor 255) gives phases of exactly `255 * 2^MAX_EXP + OFFSET` clocks, with no counter overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Enables SCL generation; low holds SCL high |
| cfg_i | input | 2*DIV_W+EXP_W | Configuration word: {exponent, high divisor, low divisor} |
| scl_o | output | 1 | SCL level request (1 = released high) |
| drive_stb_o | output | 1 | Mid-low-phase strobe (data change point) |
| sample_stb_o | output | 1 | Mid-high-phase strobe (sample point) |

## Verification
The bench sweeps every exponent value with several unequal low/high divisor pairs, including a zero divisor that leaves only the offset. Swapped fields or a shared divisor would show up as wrong phase lengths, and an off-by-one reload would make every phase one cycle long or short. A second instance with maximum exponent 5 and offset 3 receives exponent codes 6 and 7. A missing clamp would stretch its phases by 2x or 4x. A configuration change made mid-phase, a run drop in the middle of a low phase, and the slowest setting cover the cases where a design could cut a phase short, leave SCL low when idle, or overflow its counter at the longest phase.

// File: rtl/scl_wavegen_pkg.sv
package scl_wavegen_pkg;
  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } scl_lvl_e;
endpackage

// File: rtl/scl_phase_len.sv
module scl_phase_len #(
  parameter int DIV_W   = 8,
  parameter int MAX_EXP = 7,
  parameter int EXP_W   = 3,
  parameter int OFFSET  = 4,
  parameter int CNT_W   = 16,
  localparam int CFG_W  = 2*DIV_W + EXP_W
) (
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             sel_high_i,
  output logic [CNT_W-1:0] len_o
);
  logic [DIV_W-1:0] div;
  logic [EXP_W-1:0] exp_raw, exp_eff;

  assign div     = sel_high_i ? cfg_i[2*DIV_W-1:DIV_W] : cfg_i[DIV_W-1:0];
  assign exp_raw = cfg_i[CFG_W-1 -: EXP_W];

  // clamp only when the field can encode more than MAX_EXP
  generate
    if (((1 << EXP_W) - 1) == MAX_EXP) begin : g_noclamp
      assign exp_eff = exp_raw;
    end else begin : g_clamp
      assign exp_eff = (exp_raw > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : exp_raw;
    end
  endgenerate

  assign len_o = (CNT_W'(div) << exp_eff) + CNT_W'(OFFSET);

  always_comb begin
    assert (exp_eff <= EXP_W'(MAX_EXP)) else $error("assert_exp_clamp_R4");
  end
endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] load_len_i,
  output logic             scl_o,
  output logic             running_o,
  output logic             at_mid_o
);
  logic             scl_q, running_q;
  logic [CNT_W-1:0] cnt_q, half_q;
  logic             reload;

  assign reload = !running_q || (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q     <= 1'b1;
      running_q <= 1'b0;
      cnt_q     <= '0;
      half_q    <= '0;
    end else if (!run_i) begin
      scl_q     <= 1'b1;
      running_q <= 1'b0;
      cnt_q     <= '0;
      half_q    <= '0;
    end else if (reload) begin
      running_q <= 1'b1;
      scl_q     <= running_q ? ~scl_q : 1'b0;
      cnt_q     <= load_len_i - CNT_W'(1);
      half_q    <= load_len_i >> 1;
    end else begin
      cnt_q     <= cnt_q - CNT_W'(1);
    end
  end

  assign scl_o     = scl_q;
  assign running_o = running_q;
  assign at_mid_o  = running_q && (cnt_q == half_q);

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && running_q && cnt_q != '0) |=> $stable(scl_q));

  assert_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && running_q && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/scl_wavegen.sv
module scl_wavegen
  import scl_wavegen_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int MAX_EXP = 7,
  parameter int OFFSET  = 4,
  localparam int EXP_W  = $clog2(MAX_EXP + 1),
  localparam int CFG_W  = 2*DIV_W + EXP_W,
  localparam int CNT_W  = DIV_W + MAX_EXP + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             scl_o,
  output logic             drive_stb_o,
  output logic             sample_stb_o
);
  logic [CNT_W-1:0] next_len;
  logic             running, at_mid, sel_high;
  scl_lvl_e         lvl;

  assign lvl = scl_lvl_e'(scl_o);
  // the phase about to load is high only when leaving a running low phase
  assign sel_high = running && (lvl == LVL_LOW);

  scl_phase_len #(
    .DIV_W(DIV_W), .MAX_EXP(MAX_EXP), .EXP_W(EXP_W),
    .OFFSET(OFFSET), .CNT_W(CNT_W)
  ) i_len (
    .cfg_i(cfg_i), .sel_high_i(sel_high), .len_o(next_len)
  );

  scl_phase_ctr #(.CNT_W(CNT_W)) i_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .load_len_i(next_len),
    .scl_o(scl_o), .running_o(running), .at_mid_o(at_mid)
  );

  assign drive_stb_o  = at_mid && (lvl == LVL_LOW);
  assign sample_stb_o = at_mid && (lvl == LVL_HIGH);

  assert_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (scl_o && !drive_stb_o && !sample_stb_o));

  assert_start_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !running) |=> !scl_o);

  assert_drive_once_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_stb_o |=> !drive_stb_o);

  assert_sample_once_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_stb_o |=> !sample_stb_o);
endmodule

// File: tb/test_scl_wavegen.sv
module test_scl_wavegen;
  localparam int CW = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_r = 1'b0;
  logic [CW-1:0] cfg_r = '0;
  logic scl_a, drv_a, smp_a, scl_b, drv_b, smp_b;

  int checks = 0, errors = 0;
  int prev[2], cnt[2], idx[2], n[2], trans[2], bad[2];
  int low_len[2], high_len[2], low_idx[2], high_idx[2], low_n[2], high_n[2];

  always #10 clk = ~clk;

  scl_wavegen #(.DIV_W(8), .MAX_EXP(7), .OFFSET(4)) i_scl_wavegen (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run_r), .cfg_i(cfg_r),
    .scl_o(scl_a), .drive_stb_o(drv_a), .sample_stb_o(smp_a));

  scl_wavegen #(.DIV_W(8), .MAX_EXP(5), .OFFSET(3)) i_scl_wavegen_b (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run_r), .cfg_i(cfg_r),
    .scl_o(scl_b), .drive_stb_o(drv_b), .sample_stb_o(smp_b));

  task automatic observe(int k, logic s, logic d, logic p);
    if (int'(s) != prev[k]) begin
      if (prev[k] == 0) begin
        low_len[k] = cnt[k]; low_idx[k] = idx[k]; low_n[k] = n[k];
      end else begin
        high_len[k] = cnt[k]; high_idx[k] = idx[k]; high_n[k] = n[k];
      end
      trans[k]++; cnt[k] = 0; n[k] = 0; idx[k] = -1;
    end
    if ((!s && p) || (s && d)) bad[k]++;
    if (s ? p : d) begin n[k]++; idx[k] = cnt[k]; end
    cnt[k]++; prev[k] = int'(s);
  endtask

  initial begin
    for (int k = 0; k < 2; k++) begin
      prev[k] = 1; cnt[k] = 0; idx[k] = -1; n[k] = 0; trans[k] = 0; bad[k] = 0;
    end
  end

  always @(negedge clk) if (rst_n) begin
    observe(0, scl_a, drv_a, smp_a);
    observe(1, scl_b, drv_b, smp_b);
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int c);
    repeat (c) @(posedge clk);
    #2;
  endtask

  task automatic wait_trans(int k, int target);
    while (trans[k] < target) @(posedge clk);
    #2;
  endtask

  function automatic int plen(int dv, int e, int mx, int off);
    return (dv << ((e > mx) ? mx : e)) + off;
  endfunction

  // idle, start from idle, then measure one complete low and high phase
  task automatic run_cfg(int k, int e, int hi, int lo, int mx, int off, string tag);
    int t, el, eh;
    run_r = 1'b0;
    cfg_r = {3'(e), 8'(hi), 8'(lo)};
    step(3);
    t = trans[k];
    run_r = 1'b1;
    wait_trans(k, t + 3);
    el = plen(lo, e, mx, off);
    eh = plen(hi, e, mx, off);
    chk({tag, " R2 low len"}, low_len[k], el);
    chk({tag, " R3 high len"}, high_len[k], eh);
    chk({tag, " R7 drive count"}, low_n[k], 1);
    chk({tag, " R7 drive index"}, low_idx[k], el - 1 - el / 2);
    chk({tag, " R8 sample count"}, high_n[k], 1);
    chk({tag, " R8 sample index"}, high_idx[k], eh - 1 - eh / 2);
  endtask

  task automatic finish_run;
    chk("R9 strobe level A", bad[0], 0);
    chk("R9 strobe level B", bad[1], 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int t;
    int pairs_lo[3] = '{1, 5, 0};
    int pairs_hi[3] = '{2, 3, 7};
    step(3);
    rst_n = 1'b1;
    step(2);
    // R1 reset/idle state
    chk("R1 reset scl", int'(scl_a), 1);
    chk("R1 reset strobes", int'(drv_a | smp_a), 0);

    // sweep every exponent, several divisor pairs (R2 R3 R4 R7 R8)
    for (int e = 0; e < 8; e++)
      for (int p = 0; p < 3; p++)
        run_cfg(0, e, pairs_hi[p], pairs_lo[p], 7, 4, "sweep");

    // R4 clamp on instance with MAX_EXP=5, OFFSET=3
    run_cfg(1, 5, 2, 1, 5, 3, "R4 exp5");
    run_cfg(1, 6, 2, 1, 5, 3, "R4 exp6 clamp");
    run_cfg(1, 7, 1, 3, 5, 3, "R4 exp7 clamp");

    // R5 start + R6 mid-phase config change
    run_r = 1'b0;
    cfg_r = {3'd0, 8'd0, 8'd20};
    step(3);
    run_r = 1'b1;
    step(1);
    chk("R5 scl low after start", int'(scl_a), 0);
    t = trans[0];
    step(5);
    cfg_r = {3'd0, 8'd0, 8'd2};
    wait_trans(0, t + 2);
    chk("R6 current phase keeps old length", low_len[0], 24);
    wait_trans(0, t + 4);
    chk("R6 next phase uses new length", low_len[0], 6);
    chk("R6 high phase unchanged", high_len[0], 4);

    // R1 run drop inside a low phase
    run_r = 1'b0;
    cfg_r = {3'd0, 8'd50, 8'd50};
    step(3);
    run_r = 1'b1;
    step(10);
    chk("R1 precondition scl low", int'(scl_a), 0);
    run_r = 1'b0;
    step(1);
    chk("R1 scl high after run drop", int'(scl_a), 1);
    chk("R1 strobes low after run drop", int'(drv_a | smp_a), 0);
    t = trans[0];
    step(40);
    chk("R1 scl stays high when idle", int'(scl_a), 1);
    chk("R1 no edges when idle", trans[0] - t, 1);

    // R10 slowest setting
    run_cfg(0, 7, 255, 255, 7, 4, "R10 slowest");

    finish_run();
  end
endmodule